// File: doc/BRIEF.md
# Eight-Level Rotating-Priority Interrupt Controller Core

This core gathers eight level-sensitive interrupt request lines, masks them, and tracks which levels the processor is currently serving. A priority scan begins at a programmable base level, wraps modulo eight, and picks the first unmasked request. The scan stops early if it reaches a level that is already in service. The core raises `intr` toward the CPU. It then follows the CPU's acknowledge pulses and places the right bytes on its data output during each pulse.

The choice made at the first acknowledge pulse is held until the final pulse of the sequence. Requests that arrive in between are recorded, but they cannot change the vector being delivered. The core supports two sequence lengths:
- A two-pulse mode, where the second pulse carries the vector.
- A three-pulse mode, which delivers a call opcode, then the vector byte, then a page byte.

Software reaches the core through a small write port. Through it, software sets the mask, the vector base, the page byte and the control settings, and it issues a non-specific end-of-interrupt.

Top module: `irq_ctrl_core`

## Requirements
- R1: After reset, `intr` and `data_oe` are low, all eight levels are masked (mask register = 8'hFF), the base level is 0, the vector base and page byte are 0, and the two-pulse mode is selected.
- R2: A request reaches `intr` with a fixed latency. Assume it is unmasked, not in service, and the only one pending. Then `intr` is still low after the second rising clock edge that follows the request, and it is high after the third.
- R3: A request whose mask bit is set (write port select 0, bit n = 1 masks level n) never raises `intr` on its own.
- R4: The winner is the first unmasked requesting level in the order base, base+1, and so on, wrapping modulo 8. The base level is bits [2:0] of a control write (select 3 with bit 7 = 0).
- R5: The first acknowledge pulse sets the in-service bit of the selected level. During the scan, an in-service level stops the search, so every level after it in scan order stays blocked. The in-service level itself also stays blocked.
- R6: From the first acknowledge pulse until the last one, the delivered level is frozen and `intr` is low, whatever the requests do.
- R7: In two-pulse mode (control bit 3 = 1), the first pulse leaves `data_oe` low. The second pulse drives `data_oe` high with the byte {vector base bits [7:3], level}. The vector base is written on select 1.
- R8: In three-pulse mode (control bit 3 = 0), the three pulses drive the byte 8'hCD, then the vector byte, then the page byte. The page byte is written on select 2.
- R9: If no level qualifies at the first pulse, the vector carries the lowest-priority level, (base + 7) mod 8, and no in-service bit is set.
- R10: A control write with bit 7 = 1 is a non-specific end-of-interrupt. It clears only the in-service bit that comes first in scan order from the base level, and its other bits are ignored.
- R11: After the final pulse, the selection is re-run from the current state. A still-pending request at a higher priority than every in-service level then raises `intr` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Level-sensitive request lines, bit n = level n |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sel | input | 2 | 0 mask, 1 vector base, 2 page byte, 3 control/end-of-interrupt |
| wr_data | input | 8 | Write data |
| inta | input | 1 | Acknowledge pulse, one cycle wide per pulse |
| intr | output | 1 | Interrupt request to the CPU |
| data_out | output | 8 | Byte for the current acknowledge pulse |
| data_oe | output | 1 | High while data_out carries a valid byte |

## Verification
The bench sweeps every base level against a range of request and mask patterns and predicts each winner by walking the priority ranks arithmetically. A resolver with a wrong wrap direction, or one that ignores the mask, would return the wrong vector or raise `intr` spuriously.

A nested-service run checks that an active in-service level blocks lower levels but lets higher ones through. It also checks that end-of-interrupt releases the highest in-service level first. A design that cleared the wrong bit would leave a request stuck or release one too early.

Further runs cover three edge cases:
- A higher request that arrives between acknowledge pulses must not change the delivered vector.
- A request withdrawn before the first pulse must yield the lowest-priority level without entering service.
- The three-pulse byte order must be correct.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_N = 8;
  localparam int LVL_W = $clog2(LVL_N);

  typedef logic [LVL_N-1:0] lvl_vec_t;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef struct packed {
    logic hit;
    lvl_t lvl;
  } pick_t;

  // rotating scan over requests; an in-service level halts the walk
  function automatic pick_t scan_requests(lvl_vec_t req, lvl_vec_t msk,
                                          lvl_vec_t insvc, lvl_t base);
    pick_t r;
    logic  stop;
    lvl_t  j;
    r    = '0;
    stop = 1'b0;
    for (int i = 0; i < LVL_N; i++) begin
      j = base + lvl_t'(i);
      if (!stop) begin
        if (insvc[j]) begin
          stop = 1'b1;
        end else if (req[j] && !msk[j]) begin
          r.hit = 1'b1;
          r.lvl = j;
          stop  = 1'b1;
        end
      end
    end
    return r;
  endfunction

  // first in-service level in scan order from base
  function automatic pick_t scan_insvc(lvl_vec_t insvc, lvl_t base);
    pick_t r;
    lvl_t  j;
    r = '0;
    for (int i = LVL_N - 1; i >= 0; i--) begin
      j = base + lvl_t'(i);
      if (insvc[j]) begin
        r.hit = 1'b1;
        r.lvl = j;
      end
    end
    return r;
  endfunction

  function automatic lvl_t lowest_level(lvl_t base);
    return base - lvl_t'(1);
  endfunction

  function automatic logic [7:0] vector_byte(logic [7-LVL_W:0] vhi, lvl_t lvl);
    return {vhi, lvl};
  endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver
  import irqc_pkg::*;
(
  input  lvl_vec_t req,
  input  lvl_vec_t msk,
  input  lvl_vec_t insvc,
  input  lvl_t     base,
  output logic     hit,
  output lvl_t     lvl
);
  pick_t p;
  always_comb p = scan_requests(req, msk, insvc, base);
  assign hit = p.hit;
  assign lvl = p.lvl;
endmodule

// File: rtl/irqc_ack_seq.sv
module irqc_ack_seq
  import irqc_pkg::*;
#(
  parameter logic [7:0] OPC_BYTE = 8'hCD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inta,
  input  logic             two_pulse,
  input  logic             code_valid,
  input  lvl_t             code_lvl,
  input  lvl_t             base,
  input  logic [7-LVL_W:0] vbase_hi,
  input  logic [7:0]       page,
  output logic             frozen,
  output logic             first_pulse,
  output logic             last_pulse,
  output logic [7:0]       data_out,
  output logic             data_oe
);
  localparam int CNT_W = 2;

  logic [CNT_W-1:0] cnt;
  logic             mode_lat;
  logic             eff_two;
  logic [CNT_W-1:0] last_idx;
  lvl_t             ack_lvl;

  assign eff_two     = (cnt == '0) ? two_pulse : mode_lat;
  assign last_idx    = eff_two ? CNT_W'(1) : CNT_W'(2);
  assign first_pulse = inta && (cnt == '0);
  assign last_pulse  = inta && (cnt == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      mode_lat <= 1'b1;
      frozen   <= 1'b0;
      ack_lvl  <= '0;
    end else begin
      if (first_pulse) begin
        frozen   <= 1'b1;
        mode_lat <= two_pulse;
        ack_lvl  <= code_valid ? code_lvl : lowest_level(base);
      end
      if (inta) cnt <= last_pulse ? '0 : cnt + CNT_W'(1);
      if (last_pulse) frozen <= 1'b0;
    end
  end

  always_comb begin
    data_oe  = 1'b0;
    data_out = 8'h00;
    if (inta) begin
      if (eff_two) begin
        if (cnt == CNT_W'(1)) begin
          data_oe  = 1'b1;
          data_out = vector_byte(vbase_hi, ack_lvl);
        end
      end else begin
        data_oe = 1'b1;
        case (cnt)
          CNT_W'(0): data_out = OPC_BYTE;
          CNT_W'(1): data_out = vector_byte(vbase_hi, ack_lvl);
          default:   data_out = page;
        endcase
      end
    end
  end

  // R7 R8
  ack_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt <= (mode_lat ? CNT_W'(1) : CNT_W'(2))));

  // R6
  freeze_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> frozen);
endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
  import irqc_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] OPC_BYTE    = 8'hCD,
  parameter logic [7:0] RST_MASK    = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       inta,
  output logic       intr,
  output logic [7:0] data_out,
  output logic       data_oe
);
  localparam int VHI_W = 8 - LVL_W;

  lvl_vec_t         req_sync;
  lvl_vec_t         imr;
  lvl_vec_t         isr;
  lvl_t             base;
  logic             two_pulse;
  logic [VHI_W-1:0] vbase_hi;
  logic [7:0]       page;
  logic             code_valid;
  lvl_t             code_lvl;

  logic             res_hit;
  lvl_t             res_lvl;
  logic             frozen, first_pulse, last_pulse;

  logic             wr_mask, wr_vec, wr_page, wr_ctl, eoi_req;
  pick_t            eoi_pick;

  assign wr_mask = wr_en && (wr_sel == 2'd0);
  assign wr_vec  = wr_en && (wr_sel == 2'd1);
  assign wr_page = wr_en && (wr_sel == 2'd2);
  assign wr_ctl  = wr_en && (wr_sel == 2'd3) && !wr_data[7];
  assign eoi_req = wr_en && (wr_sel == 2'd3) &&  wr_data[7];

  irqc_sync #(.W(LVL_N), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_in), .dout(req_sync)
  );

  irqc_resolver i_res (
    .req(req_sync), .msk(imr), .insvc(isr), .base(base),
    .hit(res_hit), .lvl(res_lvl)
  );

  irqc_ack_seq #(.OPC_BYTE(OPC_BYTE)) i_ack (
    .clk(clk), .rst_n(rst_n), .inta(inta), .two_pulse(two_pulse),
    .code_valid(code_valid), .code_lvl(code_lvl), .base(base),
    .vbase_hi(vbase_hi), .page(page), .frozen(frozen),
    .first_pulse(first_pulse), .last_pulse(last_pulse),
    .data_out(data_out), .data_oe(data_oe)
  );

  always_comb eoi_pick = scan_insvc(isr, base);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imr       <= RST_MASK;
      base      <= '0;
      two_pulse <= 1'b1;
      vbase_hi  <= '0;
      page      <= '0;
    end else begin
      if (wr_mask) imr      <= wr_data;
      if (wr_vec)  vbase_hi <= wr_data[7:LVL_W];
      if (wr_page) page     <= wr_data;
      if (wr_ctl) begin
        base      <= wr_data[LVL_W-1:0];
        two_pulse <= wr_data[3];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr <= '0;
    end else begin
      lvl_vec_t nxt;
      nxt = isr;
      if (eoi_req && eoi_pick.hit) nxt[eoi_pick.lvl] = 1'b0;
      if (first_pulse && code_valid) nxt[code_lvl] = 1'b1;
      isr <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_valid <= 1'b0;
      code_lvl   <= '0;
    end else if (last_pulse) begin
      code_valid <= 1'b0;
    end else if (!frozen && !first_pulse) begin
      code_valid <= res_hit;
      code_lvl   <= res_lvl;
    end
  end

  assign intr = code_valid && !frozen;

  // R6
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !last_pulse) |=> (code_lvl == $past(code_lvl)) && !intr);

  // R5
  isr_set_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !first_pulse |=> ((isr & ~$past(isr)) == '0));

  // R9
  spurious_no_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_pulse && !code_valid && !eoi_req) |=> (isr == $past(isr)));

  // R10
  eoi_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && (isr != '0) && !first_pulse) |=>
      ($countones(isr) + 1 == $countones($past(isr))));
endmodule

// File: tb/test_irq_ctrl_core.sv
module test_irq_ctrl_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       inta = 1'b0;
  logic       intr;
  logic [7:0] data_out;
  logic       data_oe;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_ctrl_core i_irq_ctrl_core (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .inta(inta), .intr(intr),
    .data_out(data_out), .data_oe(data_oe)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(output logic [7:0] d, output logic oe);
    @(negedge clk);
    inta = 1'b1;
    #5;
    d = data_out; oe = data_oe;
    @(negedge clk);
    inta = 1'b0;
  endtask

  // expected winner by priority rank; returns -1 when none qualifies
  function automatic int pick(input logic [7:0] req, input logic [7:0] msk,
                              input logic [7:0] busy, input int b);
    for (int rank = 0; rank < 8; rank++) begin
      int lv;
      lv = (b + rank) % 8;
      if (busy[lv]) return -1;
      if (req[lv] && !msk[lv]) return lv;
    end
    return -1;
  endfunction

  localparam logic [7:0] VBASE = 8'hB0;

  initial begin : watchdog
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [7:0] d0, d1, d2;
    logic       o0, o1, o2;
    int         w;

    idle(2);
    #5;
    // R1 reset values
    check("R1 intr in reset", {7'd0, intr}, 8'd0);
    check("R1 oe in reset", {7'd0, data_oe}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    irq_in = 8'hFF;
    idle(5);
    check("R1 reset mask blocks all", {7'd0, intr}, 8'd0);
    irq_in = 8'h00;
    idle(3);

    wr(2'd1, VBASE);
    wr(2'd0, 8'h00);

    // R2 latency
    irq_in = 8'h10;
    @(negedge clk); @(negedge clk);
    check("R2 intr low after two edges", {7'd0, intr}, 8'd0);
    @(negedge clk);
    check("R2 intr high after three edges", {7'd0, intr}, 8'd1);
    pulse(d0, o0); pulse(d1, o1);
    check("R2 vector", d1, VBASE | 8'd4);
    irq_in = 8'h00;
    wr(2'd3, 8'h80);
    idle(3);

    // R3 R4 R7 sweep over base levels and patterns
    for (int b = 0; b < 8; b++) begin
      wr(2'd3, 8'(8 | b));
      for (int k = 0; k < 16; k++) begin
        logic [7:0] pat, msk;
        pat = 8'((k * 37 + b * 11 + 1) % 256);
        msk = (k % 4 == 0) ? 8'h00 : ((k % 7 == 3) ? 8'hFF : 8'((k * 53 + b * 7) % 256));
        wr(2'd0, msk);
        irq_in = pat;
        idle(4);
        w = pick(pat, msk, 8'h00, b);
        if (w < 0) begin
          check("R3 masked or empty gives no intr", {7'd0, intr}, 8'd0);
        end else begin
          check("R4 intr for qualifying request", {7'd0, intr}, 8'd1);
          pulse(d0, o0);
          check("R7 first pulse oe low", {7'd0, o0}, 8'd0);
          idle(1);
          pulse(d1, o1);
          check("R7 second pulse oe high", {7'd0, o1}, 8'd1);
          check("R4 rotating winner vector", d1, VBASE | 8'(w));
          irq_in = 8'h00;
          wr(2'd3, 8'h80);
          idle(3);
          check("R10 intr low after eoi", {7'd0, intr}, 8'd0);
        end
        irq_in = 8'h00;
        idle(2);
      end
    end

    // R5 R10 nesting, base 0
    wr(2'd3, 8'h08);
    wr(2'd0, 8'h00);
    irq_in = 8'h08;
    idle(4);
    pulse(d0, o0); pulse(d1, o1);
    check("R5 serve level 3", d1, VBASE | 8'd3);
    irq_in = 8'h28;
    idle(4);
    check("R5 level 3 and 5 blocked", {7'd0, intr}, 8'd0);
    irq_in = 8'h2A;
    idle(4);
    check("R5 higher level 1 passes", {7'd0, intr}, 8'd1);
    pulse(d0, o0); pulse(d1, o1);
    check("R5 nested vector", d1, VBASE | 8'd1);
    idle(3);
    check("R11 intr low after nested ack", {7'd0, intr}, 8'd0);
    irq_in = 8'h28;
    wr(2'd3, 8'h80);
    idle(3);
    check("R10 first eoi frees level 1 only", {7'd0, intr}, 8'd0);
    wr(2'd3, 8'hFF);
    idle(3);
    check("R10 second eoi frees level 3", {7'd0, intr}, 8'd1);
    pulse(d0, o0); pulse(d1, o1);
    check("R10 level 3 wins again", d1, VBASE | 8'd3);
    irq_in = 8'h20;
    wr(2'd3, 8'h80);
    idle(4);
    pulse(d0, o0); pulse(d1, o1);
    check("R10 level 5 after release", d1, VBASE | 8'd5);
    irq_in = 8'h00;
    wr(2'd3, 8'h80);
    idle(3);

    // R6 R11 freeze
    irq_in = 8'h10;
    idle(4);
    pulse(d0, o0);
    irq_in = 8'h11;
    idle(4);
    check("R6 intr low while frozen", {7'd0, intr}, 8'd0);
    pulse(d1, o1);
    check("R6 frozen vector kept", d1, VBASE | 8'd4);
    @(negedge clk);
    check("R11 intr back after sequence", {7'd0, intr}, 8'd1);
    pulse(d0, o0); pulse(d1, o1);
    check("R11 higher level served", d1, VBASE | 8'd0);
    irq_in = 8'h00;
    wr(2'd3, 8'h80);
    wr(2'd3, 8'h80);
    idle(3);

    // R9 spurious, base 2
    wr(2'd3, 8'h0A);
    irq_in = 8'h20;
    idle(4);
    irq_in = 8'h00;
    idle(4);
    pulse(d0, o0); pulse(d1, o1);
    check("R9 spurious lowest level", d1, VBASE | 8'd1);
    irq_in = 8'h02;
    idle(4);
    check("R9 no in-service set", {7'd0, intr}, 8'd1);
    pulse(d0, o0); pulse(d1, o1);
    check("R9 level 1 served", d1, VBASE | 8'd1);
    irq_in = 8'h00;
    wr(2'd3, 8'h80);
    idle(3);

    // R8 three-pulse mode
    wr(2'd3, 8'h00);
    wr(2'd2, 8'hA5);
    wr(2'd1, 8'h48);
    irq_in = 8'h40;
    idle(4);
    pulse(d0, o0); pulse(d1, o1); pulse(d2, o2);
    check("R8 opcode byte", d0, 8'hCD);
    check("R8 opcode oe", {7'd0, o0}, 8'd1);
    check("R8 vector byte", d1, 8'h4E);
    check("R8 page byte", d2, 8'hA5);
    check("R8 page oe", {7'd0, o2}, 8'd1);
    idle(2);
    check("R8 intr low after three pulses", {7'd0, intr}, 8'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule